// File: doc/BRIEF.md
# IO Page Table Translation Walker

This block turns the addresses that devices issue for DMA into real memory addresses. A request carries an IO address, a direction flag and the requester's ID. The walker first reads one 64-bit segment descriptor from a table in memory. It then reads one 64-bit page descriptor from the page table that descriptor points at. It answers with either the real address or a fault. Each 256 MB segment picks its own page size: 4 KB, 64 KB, 1 MB or 16 MB.

Four 64-bit control registers sit on a small write port with a combinational read-back. They hold the descriptor table base with a master enable, a second enable in a configuration word, a latched fault record and a per-type interrupt mask. When translation is off, addresses pass straight through.

The walker is a four-state machine:

- **IDLE**: accepts a request. It goes to SEG when translation is on, or straight to RESP when it is off.
- **SEG**: holds a read of the segment descriptor until the memory answers. It goes to PAGE on a usable descriptor, or to RESP with a segment fault.
- **PAGE**: holds a read of the page descriptor until the memory answers. It always goes on to RESP, with the address or with a page fault.
- **RESP**: presents the response for exactly one cycle, then returns to IDLE.

Top module: `iopt_walker`

## Requirements
- R1: Only one walk is in flight at a time. `req_ready` is high only in IDLE and low from the accepting edge until the response cycle has passed. `rsp_valid` is a one-cycle pulse. When the memory answers in the cycle it is asked, the response appears 1 cycle after acceptance when translation is off, 2 cycles after for a segment fault, and 3 cycles after for a completed walk.
- R2: Translation is active only when origin bit 63 and configuration bit 47 are both set. Otherwise the response carries the IO address zero-extended, with no fault and no memory read.
- R3: The segment descriptor is read from {origin[51:12], 12'b0} + 8 × (IO address >> 28).
- R4: A segment descriptor whose bit 63 is clear ends the walk with a segment fault, `rsp_fault_kind` = 2'b11, and no page read.
- R5: Descriptor bits 2:0 choose the page size: 1 = 4 KB, 3 = 64 KB, 5 = 1 MB, 7 = 16 MB. Any even code ends the walk with a segment fault.
- R6: The page descriptor is read from {desc[61:12], 12'b0} + 8 × IO address[27:shift], where shift is the page size's log2.
- R7: The real address is page descriptor bits 58:shift joined with IO address bits shift-1:0.
- R8: A read needs page descriptor bit 62 and a write needs bit 63. If the needed bit is missing, the response is a page fault with kind 2'b10, so an all-zero page descriptor faults on every access. A faulting response carries address 0.
- R9: A fault is latched into the status word at the end of its response cycle, if the status is free. The word is laid out as: bit 63 = 1; bits 62:61 = fault kind; bits 34:12 = IO address bits 34:12; bit 11 = 1 for a read; bits 10:0 = requester ID.
- R10: While status bit 63 is set and no status write occurs, the status word does not change, although later faults are still reported on the response port.
- R11: A status write replaces the whole word, so writing bit 63 = 0 frees it. A fault in the same cycle as a freeing write is latched over the written value.
- R12: `irq` is high while status bit 63 is set and either the kind is 11 with mask bit 62 set, or the kind is 10 with mask bit 61 set.
- R13: `reg_sel` picks the register: 0 origin, 1 configuration, 2 status, 3 mask. `reg_rdata` shows the selected register in the same cycle, and all four registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle; request taken on this edge |
| req_addr | input | 35 | IO address |
| req_is_read | input | 1 | 1 = device read, 0 = device write |
| req_ioid | input | 11 | Requester ID |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_addr | output | 59 | Real address (0 on a fault) |
| rsp_fault | output | 1 | Response is a fault |
| rsp_fault_kind | output | 2 | 11 segment fault, 10 page fault |
| mem_rd_en | output | 1 | Descriptor read request, held until answered |
| mem_rd_addr | output | 64 | Descriptor byte address |
| mem_rd_valid | input | 1 | Read data present |
| mem_rd_data | input | 64 | Descriptor read data |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Selected register value |
| irq | output | 1 | Fault interrupt, level |

## Verification
Fault capture and a software write to the status register can land on the same clock edge. The bench provokes this by driving a status write of zero during the response cycle of a faulting request, with the status word already occupied. It then expects to read back the new fault record, not zero.

The sticky rule is exercised the other way round. A second fault arrives while the word is occupied and no write is made, and the bench expects the first record to survive while the second fault is still signalled on the response port.

// File: rtl/iopt_pkg.sv
package iopt_pkg;

    typedef enum logic [1:0] {
        WALK_IDLE,
        WALK_SEG,
        WALK_PAGE,
        WALK_RESP
    } walk_state_e;

    localparam logic [1:0] KIND_SEG  = 2'b11;
    localparam logic [1:0] KIND_PAGE = 2'b10;

    localparam logic [1:0] SEL_ORIGIN = 2'd0;
    localparam logic [1:0] SEL_CFG    = 2'd1;
    localparam logic [1:0] SEL_STATUS = 2'd2;
    localparam logic [1:0] SEL_MASK   = 2'd3;

    localparam int ORG_EN_BIT   = 63;
    localparam int ORG_BASE_HI  = 51;
    localparam int CFG_XE_BIT   = 47;
    localparam int STE_V_BIT    = 63;
    localparam int STE_BASE_HI  = 61;
    localparam int PTE_W_BIT    = 63;
    localparam int PTE_R_BIT    = 62;
    localparam int ST_V_BIT     = 63;
    localparam int ST_KIND_HI   = 62;
    localparam int ST_KIND_LO   = 61;
    localparam int ST_RD_BIT    = 11;
    localparam int MSK_SEG_BIT  = 62;
    localparam int MSK_PAGE_BIT = 61;

    localparam int PAGE_LSB   = 12;
    localparam int NUM_SIZES  = 4;
    localparam int SIZE_STEP  = 4;

endpackage

// File: rtl/iopt_regs.sv
module iopt_regs
    import iopt_pkg::*;
#(
    parameter int IOA_W  = 35,
    parameter int IOID_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        sel,
    input  logic [63:0]       wdata,
    input  logic              fault_evt,
    input  logic [1:0]        fault_kind,
    input  logic [IOA_W-1:0]  fault_ioa,
    input  logic              fault_read,
    input  logic [IOID_W-1:0] fault_ioid,
    output logic [63:0]       origin,
    output logic [63:0]       status,
    output logic [63:0]       rdata,
    output logic              xlate_on,
    output logic              irq
);

    logic [63:0] origin_q, cfg_q, status_q, mask_q;
    logic [63:0] status_nx, fault_word;

    always_comb begin
        fault_word = '0;
        fault_word[ST_V_BIT] = 1'b1;
        fault_word[ST_KIND_HI:ST_KIND_LO] = fault_kind;
        fault_word[IOA_W-1:PAGE_LSB] = fault_ioa[IOA_W-1:PAGE_LSB];
        fault_word[ST_RD_BIT] = fault_read;
        fault_word[IOID_W-1:0] = fault_ioid;
    end

    // A freeing write and a fault on the same edge: the fault wins.
    always_comb begin
        status_nx = status_q;
        if (wr_en && sel == SEL_STATUS) begin
            status_nx = wdata;
        end
        if (fault_evt && !status_nx[ST_V_BIT]) begin
            status_nx = fault_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            origin_q <= '0;
            cfg_q    <= '0;
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            if (wr_en && sel == SEL_ORIGIN) origin_q <= wdata;
            if (wr_en && sel == SEL_CFG)    cfg_q    <= wdata;
            if (wr_en && sel == SEL_MASK)   mask_q   <= wdata;
            status_q <= status_nx;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_ORIGIN: rdata = origin_q;
            SEL_CFG:    rdata = cfg_q;
            SEL_STATUS: rdata = status_q;
            SEL_MASK:   rdata = mask_q;
        endcase
    end

    assign origin   = origin_q;
    assign status   = status_q;
    assign xlate_on = origin_q[ORG_EN_BIT] & cfg_q[CFG_XE_BIT];
    assign irq      = status_q[ST_V_BIT] &&
                      ((status_q[ST_KIND_HI:ST_KIND_LO] == KIND_SEG  && mask_q[MSK_SEG_BIT]) ||
                       (status_q[ST_KIND_HI:ST_KIND_LO] == KIND_PAGE && mask_q[MSK_PAGE_BIT]));

endmodule

// File: rtl/iopt_xlate.sv
module iopt_xlate
    import iopt_pkg::*;
#(
    parameter int IOA_W     = 35,
    parameter int RA_W      = 59,
    parameter int SEG_SHIFT = 28
) (
    input  logic [IOA_W-1:0] ioa,
    input  logic             is_read,
    input  logic [63:0]      origin,
    input  logic [63:0]      ste,
    input  logic [63:0]      pte,
    output logic [63:0]      seg_addr,
    output logic             ste_ok,
    output logic [63:0]      pte_addr,
    output logic             perm_ok,
    output logic [RA_W-1:0]  ra
);

    localparam int SEG_W = IOA_W - SEG_SHIFT;

    logic [63:0]     org_base, seg_off, pt_base;
    logic [1:0]      size_idx;
    logic [63:0]     pidx_off [NUM_SIZES];
    logic [RA_W-1:0] ra_cand  [NUM_SIZES];

    assign org_base = {{(63-ORG_BASE_HI){1'b0}}, origin[ORG_BASE_HI:PAGE_LSB], {PAGE_LSB{1'b0}}};
    assign seg_off  = {{(64-SEG_W){1'b0}}, ioa[IOA_W-1:SEG_SHIFT]} << 3;
    assign seg_addr = org_base + seg_off;

    assign pt_base  = {{(63-STE_BASE_HI){1'b0}}, ste[STE_BASE_HI:PAGE_LSB], {PAGE_LSB{1'b0}}};
    assign size_idx = ste[2:1];
    assign ste_ok   = ste[STE_V_BIT] & ste[0];

    // One candidate page index and real address per supported page size.
    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        localparam int SH = PAGE_LSB + SIZE_STEP * k;
        assign pidx_off[k] = {{(64-(SEG_SHIFT-SH)){1'b0}}, ioa[SEG_SHIFT-1:SH]} << 3;
        assign ra_cand[k]  = {pte[RA_W-1:SH], ioa[SH-1:0]};
    end

    assign pte_addr = pt_base + pidx_off[size_idx];
    assign ra       = ra_cand[size_idx];
    assign perm_ok  = is_read ? pte[PTE_R_BIT] : pte[PTE_W_BIT];

endmodule

// File: rtl/iopt_walk_fsm.sv
module iopt_walk_fsm
    import iopt_pkg::*;
#(
    parameter int IOA_W  = 35,
    parameter int RA_W   = 59,
    parameter int IOID_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IOA_W-1:0]  req_addr,
    input  logic              req_is_read,
    input  logic [IOID_W-1:0] req_ioid,
    input  logic              xlate_on,
    input  logic              mem_rd_valid,
    input  logic [63:0]       mem_rd_data,
    input  logic [63:0]       seg_addr,
    input  logic [63:0]       pte_addr,
    input  logic              ste_ok,
    input  logic              perm_ok,
    input  logic [RA_W-1:0]   ra,
    output logic              req_ready,
    output logic              mem_rd_en,
    output logic [63:0]       mem_rd_addr,
    output logic              rsp_valid,
    output logic [RA_W-1:0]   rsp_addr,
    output logic              rsp_fault,
    output logic [1:0]        rsp_fault_kind,
    output logic [IOA_W-1:0]  ioa_q,
    output logic              rd_q,
    output logic [IOID_W-1:0] ioid_q,
    output logic [63:0]       ste_cur
);

    walk_state_e     state, nxt;
    logic [63:0]     ste_q;
    logic [RA_W-1:0] rsp_addr_q;
    logic            fault_q;
    logic [1:0]      kind_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= WALK_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            WALK_IDLE: if (req_valid)    nxt = xlate_on ? WALK_SEG : WALK_RESP;
            WALK_SEG:  if (mem_rd_valid) nxt = ste_ok ? WALK_PAGE : WALK_RESP;
            WALK_PAGE: if (mem_rd_valid) nxt = WALK_RESP;
            WALK_RESP:                   nxt = WALK_IDLE;
        endcase
    end

    // Walk context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ioa_q      <= '0;
            rd_q       <= 1'b0;
            ioid_q     <= '0;
            ste_q      <= '0;
            rsp_addr_q <= '0;
            fault_q    <= 1'b0;
            kind_q     <= 2'b00;
        end else begin
            case (state)
                WALK_IDLE: if (req_valid) begin
                    ioa_q      <= req_addr;
                    rd_q       <= req_is_read;
                    ioid_q     <= req_ioid;
                    fault_q    <= 1'b0;
                    kind_q     <= 2'b00;
                    rsp_addr_q <= RA_W'(req_addr);
                end
                WALK_SEG: if (mem_rd_valid) begin
                    ste_q <= mem_rd_data;
                    if (!ste_ok) begin
                        fault_q    <= 1'b1;
                        kind_q     <= KIND_SEG;
                        rsp_addr_q <= '0;
                    end
                end
                WALK_PAGE: if (mem_rd_valid) begin
                    if (perm_ok) begin
                        rsp_addr_q <= ra;
                    end else begin
                        fault_q    <= 1'b1;
                        kind_q     <= KIND_PAGE;
                        rsp_addr_q <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready      = (state == WALK_IDLE);
        mem_rd_en      = (state == WALK_SEG) || (state == WALK_PAGE);
        mem_rd_addr    = '0;
        if (state == WALK_SEG)  mem_rd_addr = seg_addr;
        if (state == WALK_PAGE) mem_rd_addr = pte_addr;
        rsp_valid      = (state == WALK_RESP);
        rsp_fault      = rsp_valid && fault_q;
        rsp_fault_kind = rsp_valid ? kind_q : 2'b00;
        rsp_addr       = rsp_valid ? rsp_addr_q : '0;
        ste_cur        = (state == WALK_SEG) ? mem_rd_data : ste_q;
    end

endmodule

// File: rtl/iopt_walker.sv
module iopt_walker
    import iopt_pkg::*;
#(
    parameter int IOA_W     = 35,
    parameter int RA_W      = 59,
    parameter int IOID_W    = 11,
    parameter int SEG_SHIFT = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [IOA_W-1:0]  req_addr,
    input  logic              req_is_read,
    input  logic [IOID_W-1:0] req_ioid,
    output logic              rsp_valid,
    output logic [RA_W-1:0]   rsp_addr,
    output logic              rsp_fault,
    output logic [1:0]        rsp_fault_kind,
    output logic              mem_rd_en,
    output logic [63:0]       mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [63:0]       mem_rd_data,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_sel,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              irq
);

    logic [63:0]       origin_w, status_w, seg_addr_w, pte_addr_w, ste_cur_w;
    logic              xlate_on_w, ste_ok_w, perm_ok_w, rd_w;
    logic [RA_W-1:0]   ra_w;
    logic [IOA_W-1:0]  ioa_w;
    logic [IOID_W-1:0] ioid_w;

    iopt_regs #(.IOA_W(IOA_W), .IOID_W(IOID_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .sel        (reg_sel),
        .wdata      (reg_wdata),
        .fault_evt  (rsp_fault),
        .fault_kind (rsp_fault_kind),
        .fault_ioa  (ioa_w),
        .fault_read (rd_w),
        .fault_ioid (ioid_w),
        .origin     (origin_w),
        .status     (status_w),
        .rdata      (reg_rdata),
        .xlate_on   (xlate_on_w),
        .irq        (irq)
    );

    iopt_xlate #(.IOA_W(IOA_W), .RA_W(RA_W), .SEG_SHIFT(SEG_SHIFT)) u_xlate (
        .ioa      (ioa_w),
        .is_read  (rd_w),
        .origin   (origin_w),
        .ste      (ste_cur_w),
        .pte      (mem_rd_data),
        .seg_addr (seg_addr_w),
        .ste_ok   (ste_ok_w),
        .pte_addr (pte_addr_w),
        .perm_ok  (perm_ok_w),
        .ra       (ra_w)
    );

    iopt_walk_fsm #(.IOA_W(IOA_W), .RA_W(RA_W), .IOID_W(IOID_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_addr       (req_addr),
        .req_is_read    (req_is_read),
        .req_ioid       (req_ioid),
        .xlate_on       (xlate_on_w),
        .mem_rd_valid   (mem_rd_valid),
        .mem_rd_data    (mem_rd_data),
        .seg_addr       (seg_addr_w),
        .pte_addr       (pte_addr_w),
        .ste_ok         (ste_ok_w),
        .perm_ok        (perm_ok_w),
        .ra             (ra_w),
        .req_ready      (req_ready),
        .mem_rd_en      (mem_rd_en),
        .mem_rd_addr    (mem_rd_addr),
        .rsp_valid      (rsp_valid),
        .rsp_addr       (rsp_addr),
        .rsp_fault      (rsp_fault),
        .rsp_fault_kind (rsp_fault_kind),
        .ioa_q          (ioa_w),
        .rd_q           (rd_w),
        .ioid_q         (ioid_w),
        .ste_cur        (ste_cur_w)
    );

endmodule

// File: rtl/iopt_walker_chk.sv
module iopt_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic        mem_rd_en,
    input logic        irq,
    input logic        reg_wr_en,
    input logic [1:0]  reg_sel,
    input logic [63:0] status
);

    assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_rsp_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_no_fetch_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !req_ready);

    assert_fault_qual_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_valid);

    assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault && !status[63] && !(reg_wr_en && reg_sel == 2'd2)) |=> status[63]);

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status[63] && !(reg_wr_en && reg_sel == 2'd2)) |=> $stable(status));

    assert_irq_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> status[63]);

endmodule

bind iopt_walker iopt_walker_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .mem_rd_en (mem_rd_en),
    .irq       (irq),
    .reg_wr_en (reg_wr_en),
    .reg_sel   (reg_sel),
    .status    (status_w)
);

// File: tb/tb_iopt_walker.sv
module tb_iopt_walker;

    logic        clk;
    logic        rst_n;
    logic        req_valid, req_ready, req_is_read;
    logic [34:0] req_addr;
    logic [10:0] req_ioid;
    logic        rsp_valid, rsp_fault;
    logic [58:0] rsp_addr;
    logic [1:0]  rsp_fault_kind;
    logic        mem_rd_en, mem_rd_valid;
    logic [63:0] mem_rd_addr, mem_rd_data;
    logic        reg_wr_en;
    logic [1:0]  reg_sel;
    logic [63:0] reg_wdata, reg_rdata;
    logic        irq;

    int checks = 0;
    int fails = 0;
    int mem_reads = 0;
    bit done = 0;

    logic [63:0] mem [bit [63:0]];
    logic [63:0] origin_m = '0, cfg_m = '0, status_m = '0, mask_m = '0;

    iopt_walker dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_is_read(req_is_read), .req_ioid(req_ioid),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
        .rsp_fault_kind(rsp_fault_kind),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    initial begin
        clk = 0;
        forever #10 clk = ~clk;
    end

    function automatic logic [63:0] memget(input logic [63:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'd0;
    endfunction

    // Memory answers in the same cycle it is asked.
    initial begin
        mem_rd_valid = 0;
        mem_rd_data  = '0;
        forever begin
            @(negedge clk);
            mem_rd_valid = mem_rd_en;
            mem_rd_data  = memget(mem_rd_addr);
            if (mem_rd_en) mem_reads++;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic model_irq();
        return status_m[63] && ((status_m[62:61] == 2'b11 && mask_m[62]) ||
                                (status_m[62:61] == 2'b10 && mask_m[61]));
    endfunction

    task automatic wr_reg(input logic [1:0] sel, input logic [63:0] d);
        @(negedge clk);
        reg_wr_en = 1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 0;
        case (sel)
            2'd0: origin_m = d;
            2'd1: cfg_m    = d;
            2'd2: status_m = d;
            default: mask_m = d;
        endcase
    endtask

    task automatic rd_reg(input logic [1:0] sel, input logic [63:0] exp, input string tag);
        reg_sel = sel;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic xact(input logic [34:0] ioa, input logic rd, input logic [10:0] ioid,
                        input logic clr, input string tag);
        logic [63:0] sa, ste, pa, pte, ra, word;
        logic        exp_fault;
        logic [1:0]  kind;
        int          sh, lat, nreads, n, reads0;
        exp_fault = 0; kind = 2'b00; ra = '0;
        if (!(origin_m[63] && cfg_m[47])) begin
            lat = 1; nreads = 0; ra = 64'(ioa);
        end else begin
            sa  = {12'b0, origin_m[51:12], 12'b0} + 64'(ioa >> 28) * 8;
            ste = memget(sa);
            nreads = 1;
            if (!ste[63] || !ste[0]) begin
                exp_fault = 1; kind = 2'b11; lat = 2;
            end else begin
                sh  = 12 + 4 * int'(ste[2:1]);
                pa  = {2'b0, ste[61:12], 12'b0} + ((64'(ioa) & 64'h0FFF_FFFF) >> sh) * 8;
                pte = memget(pa);
                nreads = 2; lat = 3;
                if (!(rd ? pte[62] : pte[63])) begin
                    exp_fault = 1; kind = 2'b10;
                end else begin
                    ra = (((pte & 64'h07FF_FFFF_FFFF_FFFF) >> sh) << sh) |
                         (64'(ioa) & ((64'd1 << sh) - 1));
                end
            end
        end
        word = '0;
        word[63] = 1'b1; word[62:61] = kind; word[34:12] = ioa[34:12];
        word[11] = rd; word[10:0] = ioid;

        @(negedge clk);
        check({tag, " R1 ready before request"}, 64'(req_ready), 64'd1);
        reads0 = mem_reads;
        req_valid = 1; req_addr = ioa; req_is_read = rd; req_ioid = ioid;
        @(negedge clk);
        req_valid = 0;
        n = 1;
        check({tag, " R1 ready low during walk"}, 64'(req_ready), 64'd0);
        while (rsp_valid !== 1'b1 && n < 20) begin
            @(negedge clk);
            n++;
        end
        check({tag, " R1 response latency"}, 64'(n), 64'(lat));
        check({tag, " fault flag"}, 64'(rsp_fault), 64'(exp_fault));
        check({tag, " fault kind"}, 64'(rsp_fault_kind), 64'(kind));
        check({tag, " address"}, 64'(rsp_addr), ra);
        if (clr) begin
            reg_wr_en = 1; reg_sel = 2'd2; reg_wdata = '0;
            status_m = '0;
        end
        if (exp_fault && !status_m[63]) status_m = word;
        @(negedge clk);
        reg_wr_en = 0;
        check({tag, " R1 single pulse"}, 64'(rsp_valid), 64'd0);
        check({tag, " R1 ready after response"}, 64'(req_ready), 64'd1);
        check({tag, " R2 descriptor reads"}, 64'(mem_reads - reads0), 64'(nreads));
        check({tag, " R12 irq"}, 64'(irq), 64'(model_irq()));
        rd_reg(2'd2, status_m, {tag, " R9 R10 status word"});
    endtask

    initial begin
        rst_n = 0; req_valid = 0; req_addr = '0; req_is_read = 0; req_ioid = '0;
        reg_wr_en = 0; reg_sel = '0; reg_wdata = '0;

        mem[64'h10000] = 64'h8000_0000_0002_0001;
        mem[64'h10008] = 64'h8000_0000_0003_0003;
        mem[64'h10010] = 64'h8000_0000_0004_0005;
        mem[64'h10018] = 64'hC000_0000_0005_0FE7;
        mem[64'h10028] = 64'h8000_0000_0007_0002;
        mem[64'h10030] = 64'h8000_0000_0006_0001;
        mem[64'h20018] = 64'hE000_0007_1234_5123;
        mem[64'h30028] = 64'h4000_0000_0ABC_0000;
        mem[64'h40018] = 64'h8000_0005_0000_0000;
        mem[64'h50028] = 64'hD800_0001_23FF_F7FF;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset ready", 64'(req_ready), 64'd1);
        check("R1 reset no response", 64'(rsp_valid), 64'd0);
        check("R12 reset irq", 64'(irq), 64'd0);
        rd_reg(2'd0, 64'd0, "R13 reset origin");
        rd_reg(2'd1, 64'd0, "R13 reset cfg");
        rd_reg(2'd2, 64'd0, "R13 reset status");
        rd_reg(2'd3, 64'd0, "R13 reset mask");

        xact(35'h1_2345_6789, 1, 11'd3, 0, "R2 all disabled");
        wr_reg(2'd0, 64'h8000_0000_0001_0000);
        rd_reg(2'd0, origin_m, "R13 origin readback");
        xact(35'h0000_3ABC, 0, 11'd4, 0, "R2 cfg enable off");
        wr_reg(2'd1, 64'h0000_8000_0000_0000);
        rd_reg(2'd1, cfg_m, "R13 cfg readback");
        wr_reg(2'd3, 64'h6000_0000_0000_0000);
        rd_reg(2'd3, mask_m, "R13 mask readback");

        xact(35'h0000_3ABC, 1, 11'd1, 0, "R3 R6 R7 4K page");
        xact(35'h1005_4321, 1, 11'd2, 0, "R5 R7 64K page");
        xact(35'h2030_0042, 0, 11'd3, 0, "R5 R7 1M page write");
        xact(35'h35AB_CDEF, 1, 11'd4, 0, "R5 R7 16M page");
        xact(35'h4000_0800, 0, 11'h155, 0, "R4 R9 invalid segment");
        xact(35'h1005_4321, 0, 11'd6, 0, "R8 R10 write to read-only");
        wr_reg(2'd2, 64'd0);
        check("R11 irq after clear", 64'(irq), 64'd0);
        rd_reg(2'd2, 64'd0, "R11 status cleared");
        xact(35'h7_F000_1000, 0, 11'h5A5, 0, "R3 R4 R9 top segment");
        wr_reg(2'd3, 64'h2000_0000_0000_0000);
        check("R12 seg fault masked", 64'(irq), 64'(model_irq()));
        wr_reg(2'd2, 64'd0);
        xact(35'h6000_2000, 1, 11'd7, 0, "R8 zero page entry");
        xact(35'h5000_0000, 1, 11'd8, 1, "R5 R11 bad size with clearing write");
        xact(35'h2030_0042, 1, 11'd9, 0, "R8 R10 read to write-only");
        wr_reg(2'd1, 64'd0);
        xact(35'h35AB_CDEF, 0, 11'd10, 0, "R2 disabled again");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule